// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block watches a software-driven heartbeat line. Software toggles the line at least once per timeout window. Each rising or falling transition restarts an internal timer. If the timer reaches the configured window without seeing a transition, the block pulls its active-low watchdog output low. The output stays low until a transition, a reset or a disable clears the timer. The window is set in milliseconds and converted into a clock-cycle count from the clock frequency parameter.

The block takes two status inputs from a neighbouring reset generator. The first is a reset-active level. It holds the timer at zero, so a fresh window starts only once reset is released. The second is a supply-low flag. It pulls the output low at once, whatever the timer state, and lets it rise again in the same cycle it clears. A disable input stands in for an unconnected heartbeat pin. While it is high the timer never expires, so the output then reports only supply-low.

The block drives no reset of its own. A system that wants a timeout to restart the processor wires the watchdog output back into its manual reset path.

Top module: `edge_wdt`

## Requirements
- R1: While rst_ni is low the timer is zero and wdt_n_o is high, provided supply_low_i is low.
- R2: Both a 0-to-1 and a 1-to-0 change of wdt_in_i clear the timer. The clear takes effect on the third rising clock edge after the change, because the input passes two synchronizer flops and one compare register.
- R3: While rst_active_i is high the timer is held at zero. After release, wdt_n_o goes low on the TIMEOUT_CYC-th rising edge that counts with no clear.
- R4: Once low because of a timeout, wdt_n_o stays low until a clear takes effect. A clear is an input transition, rst_active_i or disable_i.
- R5: While supply_low_i is high, wdt_n_o is low in the same cycle, whatever the timer state.
- R6: When supply_low_i falls and the timer has not expired, wdt_n_o is high in that same cycle, without waiting for a clock edge.
- R7: While disable_i is high the timer is held at zero, so wdt_n_o is low only when supply_low_i is high. The window starts again when disable_i falls.
- R8: An input pulse that lasts one clock period counts as two transitions, and each of them clears the timer.
- R9: TIMEOUT_CYC equals CLK_FREQ_HZ * TIMEOUT_MS / 1000. For example, 8000 Hz and 1 ms give 8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdt_in_i | input | 1 | Heartbeat line from software, asynchronous |
| rst_active_i | input | 1 | Reset generator is holding the system in reset |
| supply_low_i | input | 1 | Supply below threshold; forces the output low |
| disable_i | input | 1 | Heartbeat pin unused; the timer never expires |
| wdt_n_o | output | 1 | Watchdog output, low on timeout or supply-low |

## Verification
The heartbeat is toggled with every gap from one cycle up to a few cycles past the window, using alternating edge directions. This tells a timer that expires one cycle early or late apart from a correct one, and a clear that only works on one edge direction apart from a correct one. One-cycle pulses show whether both transitions are seen. Resets in the middle of a window and disable intervals show whether the window restarts at release, not at the last transition. Supply-low pulses are sampled right after they change, to separate combinational forcing from a registered path.

// File: rtl/edge_wdt_pkg.sv
package edge_wdt_pkg;

  // Window in clock cycles from a clock rate and a millisecond window.
  function automatic int unsigned cycles_for_ms(input longint unsigned hz,
                                                input int unsigned ms);
    longint unsigned prod;
    prod = (hz * longint'(ms)) / 64'd1000;
    return prod[31:0];
  endfunction

endpackage

// File: rtl/edge_wdt_sync.sv
module edge_wdt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/edge_wdt_edge.sv
module edge_wdt_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic toggle_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  // either direction counts
  assign toggle_o = sig_i ^ prev_q;
endmodule

// File: rtl/edge_wdt_timer.sv
module edge_wdt_timer #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned LIMIT = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clear_i)     cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o     = cnt_q;
  assign expired_o = (cnt_q == LIM);
endmodule

// File: rtl/edge_wdt.sv
module edge_wdt #(
  parameter int unsigned CLK_FREQ_HZ = 50_000_000,
  parameter int unsigned TIMEOUT_MS  = 1600,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdt_in_i,
  input  logic rst_active_i,
  input  logic supply_low_i,
  input  logic disable_i,
  output logic wdt_n_o
);
  localparam int unsigned TIMEOUT_CYC =
    edge_wdt_pkg::cycles_for_ms(longint'(CLK_FREQ_HZ), TIMEOUT_MS);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);

  logic             in_sync;
  logic             edge_det;
  logic             tmr_clear;
  logic [CNT_W-1:0] tmr_cnt;
  logic             expired;

  edge_wdt_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wdt_in_i),
    .q_o   (in_sync)
  );

  edge_wdt_edge i_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sig_i   (in_sync),
    .toggle_o(edge_det)
  );

  assign tmr_clear = edge_det | rst_active_i | disable_i;

  edge_wdt_timer #(.CNT_W(CNT_W), .LIMIT(TIMEOUT_CYC)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (tmr_clear),
    .cnt_o    (tmr_cnt),
    .expired_o(expired)
  );

  // supply-low acts without a clock edge in both directions
  assign wdt_n_o = ~(expired | supply_low_i);
endmodule

// File: rtl/edge_wdt_checker.sv
module edge_wdt_checker #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned LIMIT = 100
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_active_i,
  input logic             supply_low_i,
  input logic             disable_i,
  input logic             wdt_n_o,
  input logic             edge_det,
  input logic [CNT_W-1:0] tmr_cnt
);
  AST_EDGE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_det |=> (tmr_cnt == '0)); // R2

  AST_RST_HOLDS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_active_i |=> (tmr_cnt == '0)); // R3

  AST_CNT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_cnt <= CNT_W'(LIMIT)); // R3

  AST_LOW_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wdt_n_o && !supply_low_i && !edge_det && !rst_active_i && !disable_i)
      |=> !wdt_n_o); // R4

  AST_SUPPLY_LOW_FORCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_low_i |-> !wdt_n_o); // R5

  AST_DISABLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disable_i && $past(disable_i) && !supply_low_i) |-> wdt_n_o); // R7
endmodule

bind edge_wdt edge_wdt_checker #(.CNT_W(CNT_W), .LIMIT(TIMEOUT_CYC)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rst_active_i(rst_active_i),
  .supply_low_i(supply_low_i),
  .disable_i   (disable_i),
  .wdt_n_o     (wdt_n_o),
  .edge_det    (edge_det),
  .tmr_cnt     (tmr_cnt)
);

// File: tb/test_edge_wdt.sv
module test_edge_wdt;
  localparam int CLK_PERIOD = 10;
  localparam int FREQ = 8000;
  localparam int MS   = 1;
  localparam int T    = FREQ * MS / 1000; // R9: 8 cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdt_in = 1'b0;
  logic rst_act = 1'b1;
  logic sup_low = 1'b0;
  logic dis = 1'b0;
  logic wdt_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int clr_at = 0;
  bit sched [16];
  string cur_req = "R1";

  edge_wdt #(.CLK_FREQ_HZ(FREQ), .TIMEOUT_MS(MS), .SYNC_STAGES(2)) i_edge_wdt (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wdt_in_i    (wdt_in),
    .rst_active_i(rst_act),
    .supply_low_i(sup_low),
    .disable_i   (dis),
    .wdt_n_o     (wdt_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cyc=%0d wdt_n_o actual=%0b expected=%0b", req, cyc, act, exp);
    end
  endtask

  // per-cycle comparison against the window arithmetic
  always @(posedge clk) begin
    cyc++;
    if (sched[cyc % 16]) begin
      clr_at = cyc;
      sched[cyc % 16] = 1'b0;
    end
    if (!rst_n || rst_act || dis) clr_at = cyc;
    #(CLK_PERIOD/4);
    check(cur_req, wdt_n, !(sup_low || ((cyc - clr_at) >= T)));
  end

  // R2: the change is seen on the third rising edge after it is driven
  task automatic toggle();
    @(negedge clk);
    wdt_in = ~wdt_in;
    sched[(cyc + 3) % 16] = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(1);
    check("R1", wdt_n, 1'b1);
    idle(2);
    rst_n = 1'b1;
    idle(3);
    // R3: window from release of reset-active
    cur_req = "R3";
    rst_act = 1'b0;
    idle(T + 4);
    check("R4", wdt_n, 1'b0);
    // R2 sweep over gaps, alternating edge direction
    cur_req = "R2";
    for (int g = 1; g <= T + 3; g++) begin
      toggle();
      idle(g);
    end
    idle(T + 2);
    cur_req = "R4";
    idle(3);
    check("R4", wdt_n, 1'b0);
    // R8: one-cycle pulse gives two clears
    cur_req = "R8";
    toggle();
    toggle();
    idle(T + 4);
    toggle();
    toggle();
    idle(4);
    check("R8", wdt_n, 1'b1);
    // R5/R6: immediate forcing and release
    cur_req = "R5";
    toggle();
    idle(3);
    @(negedge clk);
    sup_low = 1'b1;
    #1 check("R5", wdt_n, 1'b0);
    idle(2);
    @(negedge clk);
    sup_low = 1'b0;
    #1 check("R6", wdt_n, 1'b1);
    cur_req = "R6";
    idle(T + 3);
    // R3: reset-active in mid window
    cur_req = "R3";
    toggle();
    idle(5);
    rst_act = 1'b1;
    idle(2);
    rst_act = 1'b0;
    idle(T + 3);
    check("R3", wdt_n, 1'b0);
    // R7: disable keeps the timer quiet
    cur_req = "R7";
    dis = 1'b1;
    idle(T);
    sup_low = 1'b1;
    #1 check("R7", wdt_n, 1'b0);
    idle(2);
    sup_low = 1'b0;
    #1 check("R7", wdt_n, 1'b1);
    idle(T + 2);
    dis = 1'b0;
    idle(T + 3);
    check("R7", wdt_n, 1'b0);
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule